// File: doc/BRIEF.md
# Flash Command Unlock Sequencer

This block watches the write transactions of a register bus and guards the protected operations of a configuration flash. A fixed two-write key sequence at one unlock offset must arrive first, and only in the 24-bit address space with full 32-bit data. After that sequence, a third key write at the same offset issues a bulk erase. A write to the program-address offset instead opens a programming window, and in that window every write to the program-data offset becomes one program command.

Commands go to an SPI flash engine over a start/busy handshake. The engine then runs the operation on its own. In programming, each 32-bit word carries four consecutive configuration bytes in little-endian order. The byte address of the flash advances by four for every word that is accepted. While a command is pending or the engine reports busy, the busy status output is high and new commands are dropped.

Top module: `flash_unlock_seq`

## Requirements
- R1: After reset, `cmd_start_o` and `busy_o` are 0 and the sequencer is locked.
- R2: A qualified write of 0x55555555 to offset 0x55554, followed by a qualified write of 0xAAAAAAAA to the same offset, unlocks the sequencer. A further qualified write of 0xAAAAAAAA to that offset then raises `cmd_start_o` for one cycle, in the cycle after the write, with `cmd_op_o` = 0 (bulk erase).
- R3: A write is qualified only when `wr_space_i` = 2'b01 (24-bit space) and `wr_w32_i` = 1. A write with any other space code, or with narrow data, returns the sequencer to locked.
- R4: A qualified write that does not match the next expected step returns the sequencer to locked. Cycles with no write leave the sequence state unchanged.
- R5: Issuing an erase, or refusing one, leaves the sequencer locked, so a repeated 0xAAAAAAAA write issues nothing.
- R6: When unlocked, a qualified write to offset 0x55558 loads the flash byte address from the low data bits, with bits 1:0 forced to 0, and opens the programming window.
- R7: In the programming window, each qualified write to offset 0x5555C issues `cmd_op_o` = 1 (program) in the next cycle. `cmd_addr_o` holds the current byte address, and `cmd_data_o[8k+7:8k]` holds the byte for address `cmd_addr_o`+k. The address then advances by 4. A qualified write to any other offset closes the window and locks.
- R8: `busy_o` is 1 from the cycle `cmd_start_o` rises until the engine's busy input falls. A command write while `busy_o` is 1 issues nothing, and a dropped program word does not advance the address.
- R9: `cmd_start_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Bus write strobe, one cycle per write |
| wr_space_i | input | 2 | Address space code of the write (2'b01 = 24-bit space) |
| wr_w32_i | input | 1 | Write carries full 32-bit data |
| wr_addr_i | input | 24 | Write offset |
| wr_data_i | input | 32 | Write data |
| eng_busy_i | input | 1 | Flash engine busy |
| cmd_start_o | output | 1 | One-cycle command start to the engine |
| cmd_op_o | output | 1 | Command kind: 0 erase, 1 program |
| cmd_addr_o | output | 24 | Flash byte address of a program command |
| cmd_data_o | output | 32 | Program bytes, lane k for address + k |
| busy_o | output | 1 | Command pending or engine busy |

## Verification
The bench targets four corner cases. The first is a broken sequence: a key write in the wrong space, with narrow data, or to a foreign offset between the two keys. A design that failed to relock on these would issue an erase that was never properly unlocked. The second is the repeated third key write after an erase. A sequencer that stayed unlocked would erase twice. The third is a program word written while the engine is still busy. A design that dropped the word but still advanced the address would leave a four-byte hole, so the next issued address would be off by four. The last is an erase key arriving during a busy program. The bench checks that nothing is issued and that the sequencer ends locked.

// File: rtl/flash_unlock_pkg.sv
package flash_unlock_pkg;
  typedef enum logic [1:0] {
    SEQ_LOCKED = 2'd0,
    SEQ_HALF   = 2'd1,
    SEQ_OPEN   = 2'd2,
    SEQ_PROG   = 2'd3
  } seq_state_e;

  localparam logic       OP_ERASE = 1'b0;
  localparam logic       OP_PROG  = 1'b1;
  localparam logic [1:0] SP_A24   = 2'b01;
endpackage

// File: rtl/fus_bus_decode.sv
module fus_bus_decode
  import flash_unlock_pkg::*;
#(
  parameter int unsigned           ADDR_W    = 24,
  parameter int unsigned           DATA_W    = 32,
  parameter logic [ADDR_W-1:0]     UNLK_OFS  = 24'h055554,
  parameter logic [ADDR_W-1:0]     PADDR_OFS = 24'h055558,
  parameter logic [ADDR_W-1:0]     PDATA_OFS = 24'h05555C,
  parameter logic [DATA_W-1:0]     KEY_A     = 32'h5555_5555,
  parameter logic [DATA_W-1:0]     KEY_B     = 32'hAAAA_AAAA
) (
  input  logic              wr_valid_i,
  input  logic [1:0]        wr_space_i,
  input  logic              wr_w32_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_ok_o,
  output logic              wr_bad_o,
  output logic              hit_unlk_o,
  output logic              hit_paddr_o,
  output logic              hit_pdata_o,
  output logic              key_a_o,
  output logic              key_b_o
);
  logic qual;

  assign qual        = (wr_space_i == SP_A24) && wr_w32_i;
  assign wr_ok_o     = wr_valid_i && qual;
  assign wr_bad_o    = wr_valid_i && !qual;
  assign hit_unlk_o  = (wr_addr_i == UNLK_OFS);
  assign hit_paddr_o = (wr_addr_i == PADDR_OFS);
  assign hit_pdata_o = (wr_addr_i == PDATA_OFS);
  assign key_a_o     = (wr_data_i == KEY_A);
  assign key_b_o     = (wr_data_i == KEY_B);
endmodule

// File: rtl/fus_seq_fsm.sv
module fus_seq_fsm
  import flash_unlock_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_ok_i,
  input  logic wr_bad_i,
  input  logic hit_unlk_i,
  input  logic hit_paddr_i,
  input  logic hit_pdata_i,
  input  logic key_a_i,
  input  logic key_b_i,
  input  logic busy_i,
  output logic issue_erase_o,
  output logic issue_prog_o,
  output logic load_addr_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d       = state_q;
    issue_erase_o = 1'b0;
    issue_prog_o  = 1'b0;
    load_addr_o   = 1'b0;
    if (wr_bad_i) begin
      state_d = SEQ_LOCKED;
    end else if (wr_ok_i) begin
      unique case (state_q)
        SEQ_LOCKED: begin
          if (hit_unlk_i && key_a_i) state_d = SEQ_HALF;
        end
        SEQ_HALF: begin
          state_d = (hit_unlk_i && key_b_i) ? SEQ_OPEN : SEQ_LOCKED;
        end
        SEQ_OPEN: begin
          state_d = SEQ_LOCKED;
          if (hit_unlk_i && key_b_i) begin
            issue_erase_o = !busy_i;   // one-shot, relocks either way
          end else if (hit_paddr_i) begin
            load_addr_o = 1'b1;
            state_d     = SEQ_PROG;
          end
        end
        SEQ_PROG: begin
          if (hit_pdata_i) issue_prog_o = !busy_i;
          else             state_d      = SEQ_LOCKED;
        end
        default: state_d = SEQ_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEQ_LOCKED;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/fus_cmd_issue.sv
module fus_cmd_issue
  import flash_unlock_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_erase_i,
  input  logic              issue_prog_i,
  input  logic              load_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              eng_busy_i,
  output logic              cmd_start_o,
  output logic              cmd_op_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_data_o,
  output logic              busy_o
);
  localparam int unsigned BYTES  = DATA_W / 8;
  localparam int unsigned LANE_W = $clog2(BYTES);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BYTES);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] packed_d;
  logic              pend_q;

  // byte lane k goes to flash address base + k
  for (genvar k = 0; k < BYTES; k++) begin : g_lane
    assign packed_d[8*k +: 8] = wr_data_i[8*k +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q      <= '0;
      cmd_start_o <= 1'b0;
      cmd_op_o    <= OP_ERASE;
      cmd_addr_o  <= '0;
      cmd_data_o  <= '0;
      pend_q      <= 1'b0;
    end else begin
      cmd_start_o <= issue_erase_i || issue_prog_i;
      if (load_addr_i) addr_q <= {wr_data_i[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
      if (issue_erase_i) begin
        cmd_op_o   <= OP_ERASE;
        cmd_addr_o <= '0;
        cmd_data_o <= '0;
      end else if (issue_prog_i) begin
        cmd_op_o   <= OP_PROG;
        cmd_addr_o <= addr_q;
        cmd_data_o <= packed_d;
        addr_q     <= addr_q + STEP;
      end
      if (issue_erase_i || issue_prog_i) pend_q <= 1'b1;
      else if (eng_busy_i)               pend_q <= 1'b0;
    end
  end

  assign busy_o = pend_q || eng_busy_i;
endmodule

// File: rtl/flash_unlock_seq.sv
module flash_unlock_seq
  import flash_unlock_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 24,
  parameter int unsigned       DATA_W    = 32,
  parameter logic [ADDR_W-1:0] UNLK_OFS  = 24'h055554,
  parameter logic [ADDR_W-1:0] PADDR_OFS = 24'h055558,
  parameter logic [ADDR_W-1:0] PDATA_OFS = 24'h05555C,
  parameter logic [DATA_W-1:0] KEY_A     = 32'h5555_5555,
  parameter logic [DATA_W-1:0] KEY_B     = 32'hAAAA_AAAA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [1:0]        wr_space_i,
  input  logic              wr_w32_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              eng_busy_i,
  output logic              cmd_start_o,
  output logic              cmd_op_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_data_o,
  output logic              busy_o
);
  logic wr_ok, wr_bad, hit_unlk, hit_paddr, hit_pdata, key_a, key_b;
  logic issue_erase, issue_prog, load_addr;

  fus_bus_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .UNLK_OFS(UNLK_OFS),
    .PADDR_OFS(PADDR_OFS), .PDATA_OFS(PDATA_OFS), .KEY_A(KEY_A), .KEY_B(KEY_B)
  ) u_dec (
    .wr_valid_i (wr_valid_i),
    .wr_space_i (wr_space_i),
    .wr_w32_i   (wr_w32_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .wr_ok_o    (wr_ok),
    .wr_bad_o   (wr_bad),
    .hit_unlk_o (hit_unlk),
    .hit_paddr_o(hit_paddr),
    .hit_pdata_o(hit_pdata),
    .key_a_o    (key_a),
    .key_b_o    (key_b)
  );

  fus_seq_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_ok_i      (wr_ok),
    .wr_bad_i     (wr_bad),
    .hit_unlk_i   (hit_unlk),
    .hit_paddr_i  (hit_paddr),
    .hit_pdata_i  (hit_pdata),
    .key_a_i      (key_a),
    .key_b_i      (key_b),
    .busy_i       (busy_o),
    .issue_erase_o(issue_erase),
    .issue_prog_o (issue_prog),
    .load_addr_o  (load_addr)
  );

  fus_cmd_issue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .issue_erase_i(issue_erase),
    .issue_prog_i (issue_prog),
    .load_addr_i  (load_addr),
    .wr_data_i    (wr_data_i),
    .eng_busy_i   (eng_busy_i),
    .cmd_start_o  (cmd_start_o),
    .cmd_op_o     (cmd_op_o),
    .cmd_addr_o   (cmd_addr_o),
    .cmd_data_o   (cmd_data_o),
    .busy_o       (busy_o)
  );
endmodule

// File: rtl/fus_checker.sv
module fus_checker
  import flash_unlock_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 24,
  parameter int unsigned       DATA_W   = 32,
  parameter logic [ADDR_W-1:0] UNLK_OFS = 24'h055554,
  parameter logic [DATA_W-1:0] KEY_B    = 32'hAAAA_AAAA
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_valid_i,
  input logic [1:0]        wr_space_i,
  input logic              wr_w32_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              eng_busy_i,
  input logic              cmd_start_o,
  input logic              cmd_op_o,
  input logic [ADDR_W-1:0] cmd_addr_o,
  input logic [DATA_W-1:0] cmd_data_o,
  input logic              busy_o
);
  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_start_o |=> !cmd_start_o); // R9

  AST_NO_START_WHEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_start_o |-> !$past(busy_o)); // R8

  AST_ENGINE_BUSY_SHOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_busy_i |-> busy_o); // R8

  AST_ERASE_FROM_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_start_o && cmd_op_o == OP_ERASE) |->
      ($past(wr_valid_i) && $past(wr_addr_i) == UNLK_OFS && $past(wr_data_i) == KEY_B
       && $past(wr_space_i) == SP_A24 && $past(wr_w32_i))); // R2

  AST_PROG_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_start_o && cmd_op_o == OP_PROG) |-> (cmd_addr_o[1:0] == 2'b00)); // R6

  AST_PROG_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_start_o && cmd_op_o == OP_PROG) |-> (cmd_data_o == $past(wr_data_i))); // R7
endmodule

bind flash_unlock_seq fus_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .UNLK_OFS(UNLK_OFS), .KEY_B(KEY_B)
) u_fus_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_valid_i (wr_valid_i),
  .wr_space_i (wr_space_i),
  .wr_w32_i   (wr_w32_i),
  .wr_addr_i  (wr_addr_i),
  .wr_data_i  (wr_data_i),
  .eng_busy_i (eng_busy_i),
  .cmd_start_o(cmd_start_o),
  .cmd_op_o   (cmd_op_o),
  .cmd_addr_o (cmd_addr_o),
  .cmd_data_o (cmd_data_o),
  .busy_o     (busy_o)
);

// File: tb/tb_flash_unlock_seq.sv
`timescale 1ns/1ps
module tb_flash_unlock_seq;
  localparam logic [23:0] UNLK  = 24'h055554;
  localparam logic [23:0] PADDR = 24'h055558;
  localparam logic [23:0] PDATA = 24'h05555C;
  localparam logic [31:0] KA    = 32'h5555_5555;
  localparam logic [31:0] KB    = 32'hAAAA_AAAA;
  localparam int          ENG_LEN = 20;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_valid_i = 1'b0;
  logic [1:0]  wr_space_i = 2'b01;
  logic        wr_w32_i = 1'b1;
  logic [23:0] wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        eng_busy_i;
  logic        cmd_start_o, cmd_op_o, busy_o;
  logic [23:0] cmd_addr_o;
  logic [31:0] cmd_data_o;

  int checks = 0;
  int errors = 0;
  int starts = 0;
  int eng_cnt = 0;
  int cycles = 0;

  typedef struct packed { logic op; logic [23:0] addr; logic [31:0] data; } exp_t;
  exp_t exp_q[$];

  always #2 clk_i = ~clk_i;

  flash_unlock_seq dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_valid_i(wr_valid_i), .wr_space_i(wr_space_i),
    .wr_w32_i(wr_w32_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .eng_busy_i(eng_busy_i), .cmd_start_o(cmd_start_o), .cmd_op_o(cmd_op_o),
    .cmd_addr_o(cmd_addr_o), .cmd_data_o(cmd_data_o), .busy_o(busy_o)
  );

  // engine model: busy for ENG_LEN cycles after a start
  always @(posedge clk_i) begin
    if (cmd_start_o)      eng_cnt <= ENG_LEN;
    else if (eng_cnt > 0) eng_cnt <= eng_cnt - 1;
  end
  assign eng_busy_i = (eng_cnt > 0);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // monitor: pops expected commands as starts appear
  always @(negedge clk_i) begin
    if (rst_ni && cmd_start_o) begin
      starts++;
      chk(busy_o == 1'b1, "R8", "busy with start", 64'(busy_o), 64'd1);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5", "unexpected start", 64'(cmd_op_o), 64'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(cmd_op_o == e.op, e.op ? "R7" : "R2", "op", 64'(cmd_op_o), 64'(e.op));
        if (e.op) begin
          chk(cmd_addr_o == e.addr, "R7", "addr", 64'(cmd_addr_o), 64'(e.addr));
          chk(cmd_data_o == e.data, "R7", "data", 64'(cmd_data_o), 64'(e.data));
        end
      end
    end
  end

  task automatic wr(input logic [1:0] sp, input logic w, input logic [23:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_valid_i = 1'b1; wr_space_i = sp; wr_w32_i = w; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_valid_i = 1'b0;
  endtask

  task automatic wr24(input logic [23:0] a, input logic [31:0] d);
    wr(2'b01, 1'b1, a, d);
  endtask

  task automatic expect_cmd(input logic op, input logic [23:0] a, input logic [31:0] d);
    exp_t e;
    e.op = op; e.addr = a; e.data = d;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic wait_free();
    while (busy_o) @(negedge clk_i);
    idle(2);
  endtask

  task automatic check_starts(input int expv, input string req);
    idle(3);
    chk(starts == expv, req, "start count", 64'(starts), 64'(expv));
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected <20000 cycles", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    idle(3);
    // R1: reset state
    chk(cmd_start_o == 1'b0, "R1", "start at reset", 64'(cmd_start_o), 64'd0);
    chk(busy_o == 1'b0, "R1", "busy at reset", 64'(busy_o), 64'd0);
    @(negedge clk_i) rst_ni = 1'b1;
    idle(2);
    // R1: locked out of reset, a lone erase key issues nothing
    wr24(UNLK, KB);
    check_starts(0, "R1");

    // R2: unlock then erase
    expect_cmd(1'b0, '0, '0);
    wr24(UNLK, KA); wr24(UNLK, KB); wr24(UNLK, KB);
    check_starts(1, "R2");
    wait_free();

    // R3: wrong space in the middle of the sequence
    wr24(UNLK, KA); wr(2'b10, 1'b1, UNLK, KB); wr24(UNLK, KB); wr24(UNLK, KB);
    check_starts(1, "R3");
    // R3: narrow data breaks the sequence
    wr24(UNLK, KA); wr(2'b01, 1'b0, UNLK, KB); wr24(UNLK, KB); wr24(UNLK, KB);
    check_starts(1, "R3");

    // R4: foreign offset between keys
    wr24(UNLK, KA); wr24(24'h000100, 32'h1); wr24(UNLK, KB); wr24(UNLK, KB);
    check_starts(1, "R4");
    // R4: idle gaps keep the sequence
    expect_cmd(1'b0, '0, '0);
    wr24(UNLK, KA); idle(5); wr24(UNLK, KB); idle(7); wr24(UNLK, KB);
    check_starts(2, "R4");
    wait_free();

    // R5: repeated erase key after erase does nothing
    wr24(UNLK, KB);
    check_starts(2, "R5");

    // R6 / R7: programming window
    wr24(UNLK, KA); wr24(UNLK, KB); wr24(PADDR, 32'h0000_1237);
    expect_cmd(1'b1, 24'h001234, 32'h4433_2211);
    wr24(PDATA, 32'h4433_2211);
    wait_free();
    expect_cmd(1'b1, 24'h001238, 32'h8877_6655);
    wr24(PDATA, 32'h8877_6655);
    wait_free();
    expect_cmd(1'b1, 24'h00123C, 32'hDEAD_BEEF);
    wr24(PDATA, 32'hDEAD_BEEF);
    check_starts(5, "R7");
    wait_free();

    // R8: word while busy is dropped, address not advanced
    expect_cmd(1'b1, 24'h001240, 32'h0102_0304);
    wr24(PDATA, 32'h0102_0304);
    chk(busy_o == 1'b1, "R8", "busy after start", 64'(busy_o), 64'd1);
    wr24(PDATA, 32'hBAD0_BAD0);
    wait_free();
    chk(starts == 6, "R8", "dropped word", 64'(starts), 64'd6);
    expect_cmd(1'b1, 24'h001244, 32'h0A0B_0C0D);
    wr24(PDATA, 32'h0A0B_0C0D);
    check_starts(7, "R8");
    wait_free();

    // R8 / R5: erase attempt while busy is refused and relocks
    expect_cmd(1'b1, 24'h001248, 32'h5A5A_0000);
    wr24(PDATA, 32'h5A5A_0000);
    wr24(UNLK, KA); wr24(UNLK, KA); wr24(UNLK, KB);
    chk(busy_o == 1'b1, "R8", "busy before erase key", 64'(busy_o), 64'd1);
    wr24(UNLK, KB);
    wait_free();
    wr24(UNLK, KB);
    check_starts(8, "R5");

    // R7: other offset closes the window
    wr24(UNLK, KA); wr24(UNLK, KB); wr24(PADDR, 32'h0000_2000);
    wr24(24'h000200, 32'h0); wr24(PDATA, 32'h1111_1111);
    check_starts(8, "R7");

    // R9: starts stayed single-cycle (each pop above matched one start)
    chk(exp_q.size() == 0, "R9", "expected queue drained", 64'(exp_q.size()), 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule